// File: doc/BRIEF.md
# Sequential Multi-Stage Trigger Unit

This block watches a bus of probe signals and produces a single-cycle trigger pulse for a capture buffer. The trigger fires when a chain of conditions has been met in sequence. The chain has up to `MAX_STAGES` stages, a number fixed at elaboration. A run-time depth register selects how many of those stages take part. Each stage holds the following for every probe signal: an enable bit, a compare constant, a per-bit ignore mask and a comparison operator. It also holds one combine mode that joins its enabled comparisons, either all-AND or any-OR, and a cycle limit within which its condition must appear.

Software loads the configuration through a write-only port that selects a field kind, a stage and a signal. A pulse on `arm` starts a search at the first stage. If the immediate setting is on, or if no signal is enabled in any active stage, the trigger fires straight away with no condition evaluated. A stage that runs past its cycle limit abandons the search and sets a sticky timeout flag.

Top module: `trig_seq_unit`

## Requirements
- R1: Writing field kind 5 sets the active depth from `cfgData`. A value of 0 is stored as 1, and any value above `MAX_STAGES` is stored as `MAX_STAGES`. Only stages 0 to depth-1 take part, and the depth resets to `MAX_STAGES`.
- R2: The search starts at stage 0 on the clock edge that samples `arm`. The probes at that edge are not evaluated. A stage met at one edge moves the search to the next stage, which is evaluated from the following edge on. `trigPulse` rises in the cycle after the edge at which the last active stage is met.
- R3: The combine bit is field kind 3, bit 0. When it is 0 (AND), a stage is met when every enabled comparison is true, and a stage with none enabled is always met. When it is 1 (OR), a stage is met when at least one enabled comparison is true, and a stage with none enabled is never met.
- R4: The signal control field is kind 2. Bit 0 is the enable and bits 3:1 are the operator. The operator codes are: 0 masked equal, 1 masked not-equal, 2 greater, 3 greater-or-equal, 4 less, 5 less-or-equal, all unsigned, with the probe on the left. Codes 6 and 7 are never true.
- R5: A mask bit of 1 (field kind 1) removes that bit from the equal and not-equal compares. For example, a value of 0xA0 with mask 0x0F matches 0xA7 and does not match 0xB7.
- R6: A stage with a nonzero limit T (field kind 4) gets T evaluating edges. If the stage is not met at the T-th edge, `timeoutFlag` sets, `busy` falls and no trigger is produced. The flag stays set until the next `arm`.
- R7: A limit of 0 places no cycle bound on the stage.
- R8: If the immediate bit (field kind 6, bit 0) is 1, or if no signal is enabled in any active stage, `trigPulse` is high in the cycle after `arm`, and `busy` stays low.
- R9: `trigPulse` lasts one cycle. While the unit is idle and `arm` is low, no trigger occurs. `busy` is high from the cycle after a non-immediate `arm` until the trigger or a timeout.
- R10: `arm` clears `timeoutFlag`. An `arm` during a search restarts the search at stage 0.
- R11: After reset, `trigPulse`, `busy` and `timeoutFlag` are low. All compare values, masks, enables, operators, combine bits and limits are 0, and the immediate bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgKind | input | 3 | Field kind: 0 value, 1 mask, 2 signal control, 3 combine, 4 limit, 5 depth, 6 immediate |
| cfgStage | input | STG_W | Stage index of the write |
| cfgSig | input | SIG_IDX_W | Signal index of the write |
| cfgData | input | CFG_W | Write data |
| arm | input | 1 | Starts (or restarts) a search |
| probeBus | input | NUM_SIG*SIG_W | Probe signals, signal i at bits i*SIG_W upward |
| trigPulse | output | 1 | One-cycle trigger |
| busy | output | 1 | Search in progress |
| timeoutFlag | output | 1 | Sticky stage-timeout status |

## Verification
The checker watches several rules on every cycle. It confirms that the trigger is a single cycle long. It confirms that an idle unit with no `arm` stays idle and silent. It confirms that a trigger or a timeout always leaves the unit idle, that the timeout flag holds until `arm` and that `arm` clears it. Only the bench scenarios can show the rest, because it depends on the configured values. That covers which probe patterns satisfy each operator and mask, the stage ordering and the one-clock advance, AND and OR with empty stages, depth clamping, and the exact edge on which a limit expires.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [2:0] {
    KIND_VALUE   = 3'd0,
    KIND_MASK    = 3'd1,
    KIND_SIGCTRL = 3'd2,
    KIND_COMBINE = 3'd3,
    KIND_LIMIT   = 3'd4,
    KIND_DEPTH   = 3'd5,
    KIND_IMMED   = 3'd6
  } cfgKind_e;

  localparam logic [2:0] OP_EQ = 3'd0;
  localparam logic [2:0] OP_NE = 3'd1;
  localparam logic [2:0] OP_GT = 3'd2;
  localparam logic [2:0] OP_GE = 3'd3;
  localparam logic [2:0] OP_LT = 3'd4;
  localparam logic [2:0] OP_LE = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic clearStage;
    logic advanceStage;
    logic countTick;
  } seqCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic stageHit;
    logic stageLast;
    logic stageExpired;
    logic immediate;
  } seqStat_t;

endpackage

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int NUM_SIG    = 2,
  parameter int SIG_W      = 8,
  parameter int MAX_STAGES = 4,
  parameter int TMO_W      = 12,
  parameter int CFG_W      = 16,
  localparam int STG_W     = (MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1,
  localparam int SIG_IDX_W = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1,
  localparam int DEPTH_W   = $clog2(MAX_STAGES + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWe,
  input  logic [2:0]               cfgKind,
  input  logic [STG_W-1:0]         cfgStage,
  input  logic [SIG_IDX_W-1:0]     cfgSig,
  input  logic [CFG_W-1:0]         cfgData,
  input  logic [NUM_SIG*SIG_W-1:0] probeBus,
  input  seqCtrl_t                 ctrl,
  output seqStat_t                 stat
);

  logic [SIG_W-1:0]   valR  [MAX_STAGES][NUM_SIG];
  logic [SIG_W-1:0]   maskR [MAX_STAGES][NUM_SIG];
  logic [2:0]         opR   [MAX_STAGES][NUM_SIG];
  logic [NUM_SIG-1:0] enR   [MAX_STAGES];
  logic [TMO_W-1:0]   limitR[MAX_STAGES];
  logic [MAX_STAGES-1:0] orModeR;
  logic [DEPTH_W-1:0] depthR;
  logic               immedR;

  logic [STG_W-1:0]   stageIdx;
  logic [TMO_W-1:0]   cycCnt;

  logic stageOk, sigOk;
  assign stageOk = 32'(cfgStage) < MAX_STAGES;
  assign sigOk   = 32'(cfgSig) < NUM_SIG;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < MAX_STAGES; s++) begin
        for (int i = 0; i < NUM_SIG; i++) begin
          valR[s][i]  <= '0;
          maskR[s][i] <= '0;
          opR[s][i]   <= OP_EQ;
        end
        enR[s]    <= '0;
        limitR[s] <= '0;
      end
      orModeR <= '0;
      depthR  <= DEPTH_W'(MAX_STAGES);
      immedR  <= 1'b0;
    end else if (cfgWe) begin
      case (cfgKind_e'(cfgKind))
        KIND_VALUE:   if (stageOk && sigOk) valR[cfgStage][cfgSig]  <= cfgData[SIG_W-1:0];
        KIND_MASK:    if (stageOk && sigOk) maskR[cfgStage][cfgSig] <= cfgData[SIG_W-1:0];
        KIND_SIGCTRL: if (stageOk && sigOk) begin
          enR[cfgStage][cfgSig] <= cfgData[0];
          opR[cfgStage][cfgSig] <= cfgData[3:1];
        end
        KIND_COMBINE: if (stageOk) orModeR[cfgStage] <= cfgData[0];
        KIND_LIMIT:   if (stageOk) limitR[cfgStage]  <= cfgData[TMO_W-1:0];
        KIND_DEPTH: begin
          if (cfgData == '0)
            depthR <= DEPTH_W'(1);
          else if (cfgData > CFG_W'(MAX_STAGES))
            depthR <= DEPTH_W'(MAX_STAGES);
          else
            depthR <= cfgData[DEPTH_W-1:0];
        end
        KIND_IMMED:   immedR <= cfgData[0];
        default: ;
      endcase
    end
  end

  // per-signal comparators for the current stage
  logic [NUM_SIG-1:0] sigHit;
  logic [NUM_SIG-1:0] sigEn;
  assign sigEn = enR[stageIdx];

  for (genvar g = 0; g < NUM_SIG; g++) begin : gCmp
    logic [SIG_W-1:0] probe, cmpVal, careBits;
    logic [2:0]       op;
    assign probe    = probeBus[g*SIG_W +: SIG_W];
    assign cmpVal   = valR[stageIdx][g];
    assign careBits = ~maskR[stageIdx][g];
    assign op       = opR[stageIdx][g];
    always_comb begin
      case (op)
        OP_EQ:   sigHit[g] = ((probe ^ cmpVal) & careBits) == '0;
        OP_NE:   sigHit[g] = ((probe ^ cmpVal) & careBits) != '0;
        OP_GT:   sigHit[g] = probe >  cmpVal;
        OP_GE:   sigHit[g] = probe >= cmpVal;
        OP_LT:   sigHit[g] = probe <  cmpVal;
        OP_LE:   sigHit[g] = probe <= cmpVal;
        default: sigHit[g] = 1'b0;
      endcase
    end
  end

  logic andRes, orRes;
  assign andRes = &(sigHit | ~sigEn);
  assign orRes  = |(sigHit & sigEn);

  // any signal enabled among the active stages
  logic anyEnabled;
  always_comb begin
    anyEnabled = 1'b0;
    for (int s = 0; s < MAX_STAGES; s++)
      if (s < int'(depthR)) anyEnabled = anyEnabled | (|enR[s]);
  end

  logic [TMO_W-1:0] curLimit;
  assign curLimit = limitR[stageIdx];

  assign stat.stageHit     = orModeR[stageIdx] ? orRes : andRes;
  assign stat.stageLast    = (DEPTH_W'(stageIdx) + DEPTH_W'(1)) == depthR;
  assign stat.stageExpired = (curLimit != '0) && (cycCnt == curLimit - TMO_W'(1));
  assign stat.immediate    = immedR | ~anyEnabled;

  // stage pointer and per-stage cycle counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageIdx <= '0;
      cycCnt   <= '0;
    end else if (ctrl.clearStage) begin
      stageIdx <= '0;
      cycCnt   <= '0;
    end else if (ctrl.advanceStage) begin
      stageIdx <= stageIdx + STG_W'(1);
      cycCnt   <= '0;
    end else if (ctrl.countTick) begin
      cycCnt   <= cycCnt + TMO_W'(1);
    end
  end

endmodule

// File: rtl/trig_control.sv
module trig_control
  import trig_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     arm,
  input  seqStat_t stat,
  output seqCtrl_t ctrl,
  output logic     trigPulse,
  output logic     busy,
  output logic     timeoutFlag
);

  typedef enum logic {S_IDLE, S_RUN} seqState_e;
  seqState_e state, stateNext;
  logic fireNext, tmoSet, tmoClr;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    fireNext  = 1'b0;
    tmoSet    = 1'b0;
    tmoClr    = 1'b0;
    if (arm) begin
      ctrl.clearStage = 1'b1;
      tmoClr          = 1'b1;
      if (stat.immediate) begin
        fireNext  = 1'b1;
        stateNext = S_IDLE;
      end else begin
        stateNext = S_RUN;
      end
    end else if (state == S_RUN) begin
      if (stat.stageHit) begin
        if (stat.stageLast) begin
          fireNext  = 1'b1;
          stateNext = S_IDLE;
        end else begin
          ctrl.advanceStage = 1'b1;
        end
      end else if (stat.stageExpired) begin
        tmoSet    = 1'b1;
        stateNext = S_IDLE;
      end else begin
        ctrl.countTick = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      trigPulse   <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      state     <= stateNext;
      trigPulse <= fireNext;
      if (tmoClr)      timeoutFlag <= 1'b0;
      else if (tmoSet) timeoutFlag <= 1'b1;
    end
  end

  assign busy = (state == S_RUN);

endmodule

// File: rtl/trig_seq_unit.sv
module trig_seq_unit
  import trig_pkg::*;
#(
  parameter int NUM_SIG    = 2,
  parameter int SIG_W      = 8,
  parameter int MAX_STAGES = 4,
  parameter int TMO_W      = 12,
  parameter int CFG_W      = 16,
  localparam int STG_W     = (MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1,
  localparam int SIG_IDX_W = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWe,
  input  logic [2:0]               cfgKind,
  input  logic [STG_W-1:0]         cfgStage,
  input  logic [SIG_IDX_W-1:0]     cfgSig,
  input  logic [CFG_W-1:0]         cfgData,
  input  logic                     arm,
  input  logic [NUM_SIG*SIG_W-1:0] probeBus,
  output logic                     trigPulse,
  output logic                     busy,
  output logic                     timeoutFlag
);

  seqCtrl_t ctrl;
  seqStat_t stat;

  trig_datapath #(
    .NUM_SIG(NUM_SIG), .SIG_W(SIG_W), .MAX_STAGES(MAX_STAGES),
    .TMO_W(TMO_W), .CFG_W(CFG_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgKind(cfgKind), .cfgStage(cfgStage),
    .cfgSig(cfgSig), .cfgData(cfgData),
    .probeBus(probeBus), .ctrl(ctrl), .stat(stat)
  );

  trig_control i_control (
    .clk(clk), .rstN(rstN), .arm(arm), .stat(stat), .ctrl(ctrl),
    .trigPulse(trigPulse), .busy(busy), .timeoutFlag(timeoutFlag)
  );

endmodule

// File: rtl/trig_seq_checker.sv
module trig_seq_checker (
  input logic clk,
  input logic rstN,
  input logic arm,
  input logic trigPulse,
  input logic busy,
  input logic timeoutFlag
);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse && !arm |=> !trigPulse);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !arm |=> !trigPulse && !busy);

  assert_fire_ends_search_R2: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> !busy);

  assert_timeout_aborts_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> !busy && !trigPulse);

  assert_timeout_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag && !arm |=> timeoutFlag);

  assert_arm_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> !timeoutFlag);

endmodule

bind trig_seq_unit trig_seq_checker i_checker (
  .clk(clk), .rstN(rstN), .arm(arm), .trigPulse(trigPulse),
  .busy(busy), .timeoutFlag(timeoutFlag)
);

// File: tb/test_trig_seq_unit.sv
module test_trig_seq_unit;
  localparam int NS = 2, SW = 8, MS = 4, TW = 12, CW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [2:0] cfgKind = '0;
  logic [1:0] cfgStage = '0;
  logic [0:0] cfgSig = '0;
  logic [CW-1:0] cfgData = '0;
  logic arm = 1'b0;
  logic [NS*SW-1:0] probeBus = '0;
  logic trigPulse, busy, timeoutFlag;

  int nCmp = 0, nBad = 0;
  bit done = 0;
  string phase = "R11";

  always #4 clk = ~clk;

  trig_seq_unit i_trig_seq_unit (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgKind(cfgKind),
    .cfgStage(cfgStage), .cfgSig(cfgSig), .cfgData(cfgData),
    .arm(arm), .probeBus(probeBus), .trigPulse(trigPulse),
    .busy(busy), .timeoutFlag(timeoutFlag)
  );

  // ---------------- behavioural reference model ----------------
  int mVal[MS][NS], mMask[MS][NS], mOp[MS][NS];
  bit mEn[MS][NS];
  bit mOr[MS];
  int mLim[MS];
  int mDepth;
  bit mImm;
  bit mBusy, mTrig, mTmo;
  int mStage, mCnt;

  function automatic bit opTrue(int op, int p, int v, int m);
    case (op)
      0: return ((p ^ v) & ~m & 'hFF) == 0;
      1: return ((p ^ v) & ~m & 'hFF) != 0;
      2: return p > v;
      3: return p >= v;
      4: return p < v;
      5: return p <= v;
      default: return 0;
    endcase
  endfunction

  function automatic bit mStageMet(int s);
    int nEn = 0, nHit = 0;
    for (int i = 0; i < NS; i++) begin
      if (mEn[s][i]) begin
        nEn++;
        if (opTrue(mOp[s][i], int'(probeBus[i*SW +: SW]), mVal[s][i], mMask[s][i])) nHit++;
      end
    end
    if (mOr[s]) return nHit > 0;
    return nHit == nEn;
  endfunction

  function automatic bit mNoneEnabled();
    for (int s = 0; s < mDepth; s++)
      for (int i = 0; i < NS; i++)
        if (mEn[s][i]) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < MS; s++) begin
        for (int i = 0; i < NS; i++) begin
          mVal[s][i] <= 0; mMask[s][i] <= 0; mOp[s][i] <= 0; mEn[s][i] <= 0;
        end
        mOr[s] <= 0; mLim[s] <= 0;
      end
      mDepth <= MS; mImm <= 0;
      mBusy <= 0; mTrig <= 0; mTmo <= 0; mStage <= 0; mCnt <= 0;
    end else begin
      mTrig <= 0;
      if (arm) begin
        mStage <= 0; mCnt <= 0; mTmo <= 0;
        if (mImm || mNoneEnabled()) begin mTrig <= 1; mBusy <= 0; end
        else mBusy <= 1;
      end else if (mBusy) begin
        if (mStageMet(mStage)) begin
          if (mStage == mDepth - 1) begin mTrig <= 1; mBusy <= 0; end
          else begin mStage <= mStage + 1; mCnt <= 0; end
        end else if (mLim[mStage] != 0 && mCnt + 1 == mLim[mStage]) begin
          mTmo <= 1; mBusy <= 0;
        end else mCnt <= mCnt + 1;
      end
      if (cfgWe) begin
        case (int'(cfgKind))
          0: mVal[cfgStage][cfgSig] <= int'(cfgData[7:0]);
          1: mMask[cfgStage][cfgSig] <= int'(cfgData[7:0]);
          2: begin mEn[cfgStage][cfgSig] <= cfgData[0]; mOp[cfgStage][cfgSig] <= int'(cfgData[3:1]); end
          3: mOr[cfgStage] <= cfgData[0];
          4: mLim[cfgStage] <= int'(cfgData[TW-1:0]);
          5: mDepth <= (cfgData == 0) ? 1 : (int'(cfgData) > MS ? MS : int'(cfgData));
          6: mImm <= cfgData[0];
          default: ;
        endcase
      end
    end
  end

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      nCmp++;
      if (trigPulse !== mTrig || busy !== mBusy || timeoutFlag !== mTmo) begin
        nBad++;
        $display("FAIL %s cycle compare: actual trig=%0b busy=%0b tmo=%0b expected trig=%0b busy=%0b tmo=%0b",
                 phase, trigPulse, busy, timeoutFlag, mTrig, mBusy, mTmo);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic check(input string tag, input string what, input logic got, input logic exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, got, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; arm = 1'b0; cfgWe = 1'b0; probeBus = '0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic cfgWrite(input int kind, input int stg, input int sg, input int data);
    cfgWe = 1'b1; cfgKind = 3'(kind); cfgStage = 2'(stg); cfgSig = 1'(sg); cfgData = CW'(data);
    step(1);
    cfgWe = 1'b0;
  endtask

  task automatic armPulse();
    arm = 1'b1;
    step(1);
    arm = 1'b0;
  endtask

  task automatic setProbe(input int a, input int b);
    probeBus = {8'(b), 8'(a)};
  endtask

  // ---------------- scenarios ----------------
  initial begin
    step(1);
    doReset();
    phase = "R11";
    check("R11", "reset trig", trigPulse, 1'b0);
    check("R11", "reset busy", busy, 1'b0);
    check("R11", "reset timeout", timeoutFlag, 1'b0);

    // default config: nothing enabled -> immediate
    phase = "R8";
    armPulse();
    check("R8", "immediate trig", trigPulse, 1'b1);
    check("R8", "immediate busy", busy, 1'b0);
    step(1);
    check("R9", "pulse one cycle", trigPulse, 1'b0);

    // single stage equality
    phase = "R4";
    cfgWrite(5, 0, 0, 1);
    cfgWrite(0, 0, 0, 'h55);
    cfgWrite(2, 0, 0, 1);
    armPulse();
    check("R9", "busy after arm", busy, 1'b1);
    step(3);
    check("R4", "eq mismatch no trig", trigPulse, 1'b0);
    setProbe('h55, 0);
    step(1);
    check("R4", "eq match trig", trigPulse, 1'b1);

    // mask
    phase = "R5";
    doReset();
    cfgWrite(5, 0, 0, 1);
    cfgWrite(0, 0, 1, 'hA0);
    cfgWrite(1, 0, 1, 'h0F);
    cfgWrite(2, 0, 1, 1);
    armPulse();
    setProbe(0, 'hB7); step(1);
    check("R5", "masked mismatch 0xB7", trigPulse, 1'b0);
    setProbe(0, 'hA7); step(1);
    check("R5", "masked match 0xA7", trigPulse, 1'b1);

    // two stages in order
    phase = "R2";
    doReset();
    cfgWrite(5, 0, 0, 2);
    cfgWrite(0, 0, 0, 'h10); cfgWrite(2, 0, 0, 5);   // sig0 > 0x10
    cfgWrite(0, 1, 1, 3);    cfgWrite(2, 1, 1, 11);  // sig1 <= 3
    setProbe(5, 1);
    armPulse(); step(3);
    check("R2", "later stage alone no trig", trigPulse, 1'b0);
    setProbe('h20, 9); step(1);
    check("R2", "first stage met no trig", trigPulse, 1'b0);
    setProbe(0, 2); step(1);
    check("R2", "second stage met trig", trigPulse, 1'b1);
    setProbe('h20, 1);
    armPulse(); step(1);
    check("R2", "no same-cycle second stage", trigPulse, 1'b0);
    step(1);
    check("R2", "second stage next edge", trigPulse, 1'b1);

    // combine modes
    phase = "R3";
    doReset();
    cfgWrite(5, 0, 0, 1);
    cfgWrite(3, 0, 0, 1);
    cfgWrite(0, 0, 0, 'h11); cfgWrite(2, 0, 0, 1);
    cfgWrite(0, 0, 1, 'h22); cfgWrite(2, 0, 1, 1);
    armPulse();
    setProbe(0, 'h22); step(1);
    check("R3", "OR one true", trigPulse, 1'b1);
    cfgWrite(3, 0, 0, 0);
    armPulse(); step(1);
    check("R3", "AND one true no trig", trigPulse, 1'b0);
    setProbe('h11, 'h22); step(1);
    check("R3", "AND all true", trigPulse, 1'b1);
    cfgWrite(5, 0, 0, 2);                      // stage1 AND, empty
    armPulse(); step(1);
    check("R3", "stage0 met", trigPulse, 1'b0);
    step(1);
    check("R3", "empty AND stage met", trigPulse, 1'b1);
    cfgWrite(3, 1, 0, 1); cfgWrite(4, 1, 0, 3); // stage1 OR, empty, limit 3
    armPulse(); step(3);
    check("R3", "empty OR never met", timeoutFlag, 1'b0);
    step(1);
    check("R3", "empty OR times out", timeoutFlag, 1'b1);

    // timeout
    phase = "R6";
    doReset();
    cfgWrite(5, 0, 0, 1);
    cfgWrite(0, 0, 0, 'h77); cfgWrite(2, 0, 0, 1);
    cfgWrite(4, 0, 0, 5);
    armPulse(); step(4);
    check("R6", "before limit", timeoutFlag, 1'b0);
    check("R6", "busy before limit", busy, 1'b1);
    step(1);
    check("R6", "limit reached flag", timeoutFlag, 1'b1);
    check("R6", "limit reached idle", busy, 1'b0);
    check("R6", "limit no trig", trigPulse, 1'b0);
    setProbe('h77, 0); step(4);
    check("R9", "idle ignores probe", trigPulse, 1'b0);
    check("R6", "flag sticky", timeoutFlag, 1'b1);
    phase = "R10";
    setProbe(0, 0);
    armPulse();
    check("R10", "arm clears flag", timeoutFlag, 1'b0);

    // no limit
    phase = "R7";
    cfgWrite(4, 0, 0, 0);
    armPulse(); step(40);
    check("R7", "no limit still busy", busy, 1'b1);
    check("R7", "no limit no flag", timeoutFlag, 1'b0);
    setProbe('h77, 0); step(1);
    check("R7", "late match fires", trigPulse, 1'b1);

    // depth clamp
    phase = "R1";
    doReset();
    for (int s = 0; s < MS; s++) begin
      cfgWrite(0, s, 0, s + 1); cfgWrite(2, s, 0, 1);
    end
    cfgWrite(5, 0, 0, 0);
    setProbe(1, 0);
    armPulse(); step(1);
    check("R1", "depth 0 acts as 1", trigPulse, 1'b1);
    cfgWrite(5, 0, 0, 9);
    armPulse();
    for (int v = 1; v <= 3; v++) begin setProbe(v, 0); step(1); end
    check("R1", "depth clamped not early", trigPulse, 1'b0);
    setProbe(4, 0); step(1);
    check("R1", "depth clamped to max", trigPulse, 1'b1);

    // restart
    phase = "R10";
    cfgWrite(5, 0, 0, 2);
    setProbe(0, 0);
    armPulse();
    setProbe(1, 0); step(1);
    armPulse();
    setProbe(2, 0); step(1);
    check("R10", "restart returns to stage 0", trigPulse, 1'b0);
    check("R10", "restart busy", busy, 1'b1);
    setProbe(1, 0); step(1);
    setProbe(2, 0); step(1);
    check("R10", "restart then sequence", trigPulse, 1'b1);

    // immediate bit and inactive enabled stage
    phase = "R8";
    doReset();
    cfgWrite(5, 0, 0, 1);
    cfgWrite(2, 2, 0, 1);
    armPulse();
    check("R8", "enabled only in inactive stage", trigPulse, 1'b1);
    cfgWrite(0, 0, 0, 'h99); cfgWrite(2, 0, 0, 1);
    cfgWrite(6, 0, 0, 1);
    armPulse();
    check("R8", "immediate bit", trigPulse, 1'b1);
    check("R8", "immediate not busy", busy, 1'b0);

    // operator sweep with a one-edge limit
    phase = "R4";
    doReset();
    cfgWrite(5, 0, 0, 1);
    cfgWrite(4, 0, 0, 1);
    cfgWrite(0, 0, 0, 'h40);
    cfgWrite(1, 0, 0, 'h01);
    for (int op = 0; op < 8; op++) begin
      cfgWrite(2, 0, 0, (op << 1) | 1);
      for (int k = 0; k < 4; k++) begin
        int p;
        p = (k == 0) ? 'h3F : (k == 1) ? 'h40 : (k == 2) ? 'h41 : 'hC0;
        setProbe(p, 0);
        armPulse(); step(1);
        check("R4", $sformatf("op %0d probe %02h trig", op, p), trigPulse, opTrue(op, p, 'h40, 'h01));
        check("R6", $sformatf("op %0d probe %02h timeout", op, p), timeoutFlag, !opTrue(op, p, 'h40, 'h01));
      end
    end

    step(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nCmp++; nBad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule